// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Controller

This block sits between a simple on-chip request port and a three-wire (Microwire) serial EEPROM that has a chip select, a serial clock, a data-in line and a data-out line. The host issues a single-cycle start pulse with a word offset, a read/write flag and, for writes, a 16-bit data word. The block then runs the complete serial exchange on the EEPROM pins. When it is done it raises a one-cycle acknowledge, together with an error flag and, for reads, the word it fetched.

A read is a single command frame followed by 16 clocked input bits. A write is a burst of three frames. The first is an erase/write-enable command: its opcode field is two bits wider than normal and is padded with zero address bits. The second is the write command carrying the address and the data. The third is a matching disable command. Between the frames the block returns the device to standby. After the write it watches the data-out line, which the device holds low while busy. If the line does not go high within a bounded number of checks, the block gives up and reports an error. Every serial phase lasts a fixed number of system clocks, set by a divider parameter. The opcode width, the address width, the device size and the poll limit are also parameters.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `ack` and `err` are all low.
- R2: A start whose `word_addr` is at or beyond `WORDS` gets `ack` with `err` high in the next cycle, and the EEPROM pins do not change.
- R3: The serial pins change only at phase boundaries. Two pin changes are never closer than `HALF_DIV` system clocks.
- R4: A read raises `ee_cs`. It then sends the read opcode and the `ADDR_W` address bits, most significant bit first, each bit driven on `ee_di` before a rising `ee_sk`. Next it takes 16 bits from `ee_do` during the clock-high phase, MSB first. It returns them on `rdata` with `err` low.
- R5: `ee_di` is low while data is being clocked in, and it is low whenever `ee_cs` falls at the end of a frame.
- R6: A write first sends the enable command: `OP_W+2` bits (`EWEN_OP`, default 10011) followed by `ADDR_W-2` zero bits. It then sends the write opcode, the address and the 16 data bits, MSB first. Last, it sends the disable command (`EWDS_OP`, default 10000) in the same widened form. Each frame is separated from the next by a standby sequence: chip select and clock low, clock high, chip select high, clock low.
- R7: After the write frame and its standby, the block samples `ee_do` once per phase with `ee_cs` high. The first high sample ends the wait, and the write completes with `err` low.
- R8: If `ee_do` stays low for `POLL_LIMIT` samples, the block ends the transaction with `err` high and sends no disable command.
- R9: Every transaction that reached the bus ends with `ee_cs` and `ee_di` low and a single `ee_sk` pulse, and `ack` follows with all three pins low.
- R10: A start pulse that arrives while a transaction is in progress is ignored. It produces no extra acknowledge and no bus activity.
- R11: A start pulse presented in the same cycle as `ack` is accepted as a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Single-cycle start pulse |
| we | input | 1 | 1 = write, 0 = read, qualified by `req` |
| word_addr | input | 16 | Word offset in the device |
| wdata | input | 16 | Word to write |
| ack | output | 1 | One-cycle completion strobe |
| err | output | 1 | Error flag, valid with `ack` |
| rdata | output | 16 | Word returned by the last read |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data towards the EEPROM |
| ee_do | input | 1 | Serial data and ready status from the EEPROM |

## Verification
Two host-side events can land in the same cycle: the acknowledge that closes one transaction and the start pulse that opens the next. The bench reacts to a write's acknowledge by presenting a read start in that same cycle. It then expects the read to run and return the word just written. A start pulse sent in the middle of a read frame must leave no trace: the device model's command log must hold only the one read, and neither the acknowledge count nor the pin activity may move afterwards. A behavioural device model decodes every frame from the pins on each clock. It checks the phase spacing and the data-in level, and a log of the decoded commands is compared with the sequence the requirements predict.

// File: rtl/mw_pkg.sv
// Shared types for the serial EEPROM controller.
// Assumes: one word is 16 bits; the sequencer states below cover every frame.
package mw_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_READY,
        ST_EWEN,
        ST_SB1,
        ST_WRCMD,
        ST_SB2,
        ST_POLL,
        ST_SB3,
        ST_EWDS,
        ST_RDCMD,
        ST_RDDAT,
        ST_TERM
    } mw_state_e;

endpackage

// File: rtl/mw_phase_tick.sv
// Phase timer: pulses tick once every HALF_DIV clocks while run is high.
// Assumes: HALF_DIV >= 1; the count restarts whenever run is low.
module mw_phase_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    generate
        if (HALF_DIV == 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt;

            // Count the clocks inside one serial phase.
            always_ff @(posedge clk) begin
                if (!rst_n || !run)   cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/mw_tx_shift.sv
// Outgoing frame shifter: loads a left-aligned frame and presents its MSB.
// Assumes: load and shift are never high in the same cycle.
module mw_tx_shift #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);

    logic [W-1:0] sr;

    // Hold, load or advance the frame by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= load_val;
        else if (shift) sr <= {sr[W-2:0], 1'b0};
    end

    assign msb = sr[W-1];

endmodule

// File: rtl/mw_rx_shift.sv
// Incoming word shifter: collects serial bits MSB first.
// Assumes: exactly W enables form one word, so no clear is needed.
module mw_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word
);

    // Append one sampled bit at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)  word <= '0;
        else if (en) word <= {word[W-2:0], din};
    end

endmodule

// File: rtl/mw_eeprom_ctrl.sv
// Word read/write sequencer for a three-wire serial EEPROM.
// Assumes: req is a one-cycle pulse, honoured only in ST_IDLE; ADDR_W > 2;
// WORDS <= 2**ADDR_W; the device holds ee_do low while a write is busy.
module mw_eeprom_ctrl
    import mw_pkg::*;
#(
    parameter int                OFF_W      = 16,
    parameter int                OP_W       = 3,
    parameter int                ADDR_W     = 6,
    parameter int                WORDS      = 48,
    parameter int                HALF_DIV   = 4,
    parameter int                POLL_LIMIT = 200,
    parameter logic [OP_W-1:0]   RD_OP      = 3'b110,
    parameter logic [OP_W-1:0]   WR_OP      = 3'b101,
    parameter logic [OP_W+1:0]   EWEN_OP    = 5'b10011,
    parameter logic [OP_W+1:0]   EWDS_OP    = 5'b10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [OFF_W-1:0]  word_addr,
    input  logic [15:0]       wdata,
    output logic              ack,
    output logic              err,
    output logic [15:0]       rdata,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);

    localparam int CMD_W = OP_W + ADDR_W;
    localparam int TX_W  = CMD_W + WORD_W;
    localparam int BCW   = $clog2(TX_W + 1);
    localparam int PCW   = $clog2(POLL_LIMIT + 1);
    localparam logic [OFF_W:0] WORDS_L = (OFF_W + 1)'(WORDS);

    mw_state_e          state;
    logic [1:0]         sub;
    logic [BCW-1:0]     bits_left;
    logic [PCW-1:0]     polls;
    logic               is_wr;
    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  wdata_q;
    logic               tick, tx_msb, tx_load, tx_shift, rx_en, in_tx, addr_ok;
    logic [TX_W-1:0]    tx_val, rd_frame, wr_frame, en_frame, ds_frame;
    logic [WORD_W-1:0]  rx_word;

    assign addr_ok  = {1'b0, word_addr} < WORDS_L;
    assign rd_frame = {RD_OP, addr_q, {WORD_W{1'b0}}};
    assign wr_frame = {WR_OP, addr_q, wdata_q};
    assign en_frame = {EWEN_OP, {(ADDR_W-2){1'b0}}, {WORD_W{1'b0}}};
    assign ds_frame = {EWDS_OP, {(ADDR_W-2){1'b0}}, {WORD_W{1'b0}}};
    assign in_tx    = state inside {ST_EWEN, ST_WRCMD, ST_EWDS, ST_RDCMD};
    assign tx_shift = tick && in_tx && (sub == 2'd1);
    assign rx_en    = tick && (state == ST_RDDAT) && (sub == 2'd1);

    mw_phase_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .tick(tick)
    );

    mw_tx_shift #(.W(TX_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .load_val(tx_val),
        .shift(tx_shift), .msb(tx_msb)
    );

    mw_rx_shift #(.W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .din(ee_do), .word(rx_word)
    );

    // Pick the frame to load on entry to each transmit stage.
    always_comb begin
        tx_load = 1'b0;
        tx_val  = rd_frame;
        if (tick) begin
            if (state == ST_READY) begin
                tx_load = 1'b1;
                tx_val  = is_wr ? en_frame : rd_frame;
            end else if (state == ST_SB1 && sub == 2'd3) begin
                tx_load = 1'b1;
                tx_val  = wr_frame;
            end else if (state == ST_SB3 && sub == 2'd3) begin
                tx_load = 1'b1;
                tx_val  = ds_frame;
            end
        end
    end

    // Main sequencer: host handshake, frames, standby, polling, terminate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  sub <= '0;  bits_left <= '0;  polls <= '0;
            is_wr <= 1'b0;     addr_q <= '0;  wdata_q <= '0;
            ack <= 1'b0;  err <= 1'b0;  rdata <= '0;
            ee_cs <= 1'b0;  ee_sk <= 1'b0;  ee_di <= 1'b0;
        end else begin
            ack <= 1'b0;
            if (state == ST_IDLE) begin
                if (req) begin
                    if (!addr_ok) begin
                        ack <= 1'b1;
                        err <= 1'b1;
                    end else begin
                        addr_q  <= word_addr[ADDR_W-1:0];
                        wdata_q <= wdata;
                        is_wr   <= we;
                        err     <= 1'b0;
                        sub     <= '0;
                        state   <= ST_READY;
                    end
                end
            end else if (tick) begin
                unique case (state)
                    ST_READY: begin
                        ee_cs <= 1'b1;  ee_sk <= 1'b0;  ee_di <= 1'b0;
                        bits_left <= BCW'(CMD_W);
                        state <= is_wr ? ST_EWEN : ST_RDCMD;
                    end
                    ST_EWEN, ST_WRCMD, ST_EWDS, ST_RDCMD: begin
                        if (sub == 2'd0) begin
                            ee_sk <= 1'b0;  ee_di <= tx_msb;  sub <= 2'd1;
                        end else if (sub == 2'd1) begin
                            ee_sk <= 1'b1;
                            bits_left <= bits_left - 1'b1;
                            sub <= (bits_left == BCW'(1)) ? 2'd2 : 2'd0;
                        end else begin
                            ee_sk <= 1'b0;  ee_di <= 1'b0;  sub <= 2'd0;
                            if (state == ST_EWEN)       state <= ST_SB1;
                            else if (state == ST_WRCMD) state <= ST_SB2;
                            else if (state == ST_EWDS)  state <= ST_TERM;
                            else begin
                                bits_left <= BCW'(WORD_W);
                                state <= ST_RDDAT;
                            end
                        end
                    end
                    ST_SB1, ST_SB2, ST_SB3: begin
                        sub <= sub + 2'd1;
                        if (sub == 2'd0) begin
                            ee_cs <= 1'b0;  ee_sk <= 1'b0;
                        end else if (sub == 2'd1) begin
                            ee_sk <= 1'b1;
                        end else if (sub == 2'd2) begin
                            ee_cs <= 1'b1;
                        end else begin
                            ee_sk <= 1'b0;
                            if (state == ST_SB1) begin
                                bits_left <= BCW'(TX_W);  state <= ST_WRCMD;
                            end else if (state == ST_SB2) begin
                                polls <= '0;  state <= ST_POLL;
                            end else begin
                                bits_left <= BCW'(CMD_W);  state <= ST_EWDS;
                            end
                        end
                    end
                    ST_POLL: begin
                        if (ee_do) begin
                            sub <= '0;  state <= ST_SB3;
                        end else if (polls == PCW'(POLL_LIMIT - 1)) begin
                            err <= 1'b1;  sub <= '0;  state <= ST_TERM;
                        end else begin
                            polls <= polls + 1'b1;
                        end
                    end
                    ST_RDDAT: begin
                        if (sub == 2'd0) begin
                            ee_sk <= 1'b1;  sub <= 2'd1;
                        end else begin
                            ee_sk <= 1'b0;  sub <= 2'd0;
                            bits_left <= bits_left - 1'b1;
                            if (bits_left == BCW'(1)) state <= ST_TERM;
                        end
                    end
                    ST_TERM: begin
                        sub <= sub + 2'd1;
                        if (sub == 2'd0) begin
                            ee_cs <= 1'b0;  ee_di <= 1'b0;  ee_sk <= 1'b0;
                        end else if (sub == 2'd1) begin
                            ee_sk <= 1'b1;
                        end else begin
                            ee_sk <= 1'b0;  ack <= 1'b1;  sub <= '0;
                            if (!is_wr) rdata <= rx_word;
                            state <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!ee_cs && !ee_sk && !ee_di)); // R9
    AST_PINS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable({ee_cs, ee_sk, ee_di})); // R3
    AST_REJECT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req && !addr_ok) |=> (ack && err && !ee_cs)); // R2
    AST_DI_QUIET_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDDAT) |-> !ee_di); // R5
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL) |-> (polls < PCW'(POLL_LIMIT))); // R8
    AST_CS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tx || state == ST_RDDAT || state == ST_POLL) |-> ee_cs); // R4

endmodule

// File: tb/mw_eeprom_ctrl_bench.sv
// Bench: behavioural three-wire EEPROM model that decodes the pins on every
// clock, plus monitors for phase spacing and data-in level.
module mw_eeprom_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int WORDS      = 48;
    localparam int HALF_DIV   = 4;
    localparam int POLL_LIMIT = 200;
    localparam int BUSY_CYC   = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [15:0] word_addr = '0, wdata = '0;
    logic        ack, err;
    logic [15:0] rdata;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_ctrl #(.ADDR_W(ADDR_W), .WORDS(WORDS), .HALF_DIV(HALF_DIV),
                     .POLL_LIMIT(POLL_LIMIT)) u_mw_eeprom_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .word_addr(word_addr),
        .wdata(wdata), .ack(ack), .err(err), .rdata(rdata),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int n_chk = 0, n_fail = 0;

    function automatic logic [15:0] seed_word(int i);
        return 16'((i * 1811) ^ 16'hC35A);
    endfunction

    function automatic int enc(int kind, int a, int d);
        return (kind << 24) | (a << 16) | (d & 16'hFFFF);
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [15:0] mem [0:63];
    int  log_q[$];
    int  ph, cnt, op, addr, ocnt, busy, di_viol;
    logic [15:0] wd;
    bit  wen, pend, hang, term_pulse, pcs, psk;

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = seed_word(i);
        di_viol = 0; hang = 1'b0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; pend = 0; busy = 0; wen = 0; term_pulse = 0;
            pcs = 0; psk = 0; ee_do <= 1'b0;
        end else begin
            if (ee_cs && ee_sk && !psk) begin
                case (ph)
                    0: if (ee_di) begin ph = 1; cnt = 0; op = 0; end
                    1: begin
                        op = ((op << 1) | ee_di) & 3; cnt++;
                        if (cnt == 2) begin ph = 2; cnt = 0; addr = 0; end
                    end
                    2: begin
                        addr = ((addr << 1) | ee_di) & ((1 << ADDR_W) - 1); cnt++;
                        if (cnt == ADDR_W) begin
                            if (op == 2) begin
                                log_q.push_back(enc(1, addr, 0));
                                ph = 3; ocnt = 0; ee_do <= 1'b0;
                            end else if (op == 1) begin
                                ph = 4; cnt = 0; wd = '0;
                            end else begin
                                if ((addr >> (ADDR_W-2)) == 3) begin
                                    wen = 1; log_q.push_back(enc(3, addr, 0));
                                end else begin
                                    if ((addr >> (ADDR_W-2)) == 0) wen = 0;
                                    log_q.push_back(enc(4, addr, 0));
                                end
                                ph = 5;
                            end
                        end
                    end
                    3: begin
                        if (ee_di) di_viol++;
                        if (ocnt < 16) ee_do <= mem[addr][15-ocnt];
                        ocnt++;
                    end
                    4: begin
                        wd = {wd[14:0], ee_di}; cnt++;
                        if (cnt == 16) begin
                            log_q.push_back(enc(2, addr, wd)); pend = 1; ph = 5;
                        end
                    end
                    default: ;
                endcase
            end
            if (!ee_cs && ee_sk && !psk) term_pulse = 1;
            if (ee_cs && !pcs) term_pulse = 0;
            if (!ee_cs && pcs) begin
                if (ee_di) di_viol++;
                if (pend) begin
                    if (wen) mem[addr] = wd;
                    busy = BUSY_CYC; pend = 0;
                end
                ph = 0;
            end
            if (busy > 0) busy--;
            if (ph != 3) ee_do <= !hang && (busy == 0);
            pcs = ee_cs; psk = ee_sk;
        end
    end

    // ---------------- pin monitor ----------------
    logic [2:0] ppins = '0;
    int gap = 1000, phase_viol = 0, pin_changes = 0, ack_cnt = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if ({ee_cs, ee_sk, ee_di} != ppins) begin
                if (gap < HALF_DIV) phase_viol++;
                gap = 1; pin_changes++;
            end else gap++;
            ppins = {ee_cs, ee_sk, ee_di};
            if (ack) ack_cnt++;
        end
    end

    // ---------------- host tasks ----------------
    int waited;

    task automatic wait_ack();
        waited = 0;
        while (!ack && waited < 20000) begin @(negedge clk); waited++; end
        check(ack, "ack timeout", waited, 0);
    endtask

    task automatic issue(input bit w, input int a, input int d);
        req = 1'b1; we = w; word_addr = 16'(a); wdata = 16'(d);
        @(negedge clk); req = 1'b0;
        wait_ack();
    endtask

    task automatic check_end_bus(input string rq);
        check(!ee_cs && !ee_sk && !ee_di && term_pulse, rq,
              {ee_cs, ee_sk, ee_di, term_pulse}, 4'b0001);
    endtask

    task automatic check_log(input string rq, input int e[$]);
        check(log_q.size() == e.size(), rq, log_q.size(), e.size());
        if (log_q.size() == e.size())
            foreach (e[i]) check(log_q[i] == e[i], rq, log_q[i], e[i]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int pc, ac;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!ack && !err, "R1 ack/err", {ack, err}, 0);
        check({ee_cs, ee_sk, ee_di} == 3'b000, "R1 pins", {ee_cs, ee_sk, ee_di}, 0);

        // R4 plain reads, R9 ending
        log_q.delete();
        issue(0, 5, 0);
        check(!err && rdata == seed_word(5), "R4 read 5", rdata, seed_word(5));
        check_end_bus("R9 after read");
        check_log("R4 read frame", '{enc(1, 5, 0)});
        @(negedge clk);
        log_q.delete();
        issue(0, WORDS-1, 0);
        check(!err && rdata == seed_word(WORDS-1), "R4 read top", rdata, seed_word(WORDS-1));

        // R2 rejects: ack one cycle later, no pin activity
        @(negedge clk);
        pc = pin_changes;
        issue(0, WORDS, 0);
        check(err && waited == 0, "R2 reject at size", {err, waited[7:0]}, 9'h100);
        issue(1, 16'hFFFF, 16'h1111);
        check(err && waited == 0, "R2 reject far", {err, waited[7:0]}, 9'h100);
        repeat (3) @(negedge clk);
        check(pin_changes == pc, "R2 no bus", pin_changes, pc);

        // R6 R7 write burst with polling, then readback
        log_q.delete();
        issue(1, 9, 16'h1234);
        check(!err, "R7 write ok", err, 0);
        check_end_bus("R9 after write");
        check_log("R6 write frames", '{enc(3, 3 << (ADDR_W-2), 0),
                                      enc(2, 9, 16'h1234), enc(4, 0, 0)});
        @(negedge clk);
        issue(0, 9, 0);
        check(!err && rdata == 16'h1234, "R6 readback", rdata, 16'h1234);

        // R11 start in the ack cycle of a write
        @(negedge clk);
        log_q.delete();
        issue(1, 20, 16'hBEEF);
        req = 1'b1; we = 1'b0; word_addr = 16'd20;
        @(negedge clk); req = 1'b0;
        wait_ack();
        check(!err && rdata == 16'hBEEF, "R11 back-to-back read", rdata, 16'hBEEF);
        check(log_q.size() == 4, "R11 frames", log_q.size(), 4);

        // R10 start while busy is ignored
        @(negedge clk);
        log_q.delete();
        req = 1'b1; we = 1'b0; word_addr = 16'd7;
        @(negedge clk); req = 1'b0;
        repeat (30) @(negedge clk);
        req = 1'b1; we = 1'b1; word_addr = 16'd2; wdata = 16'h5555;
        @(negedge clk); req = 1'b0;
        wait_ack();
        check(rdata == seed_word(7), "R10 read intact", rdata, seed_word(7));
        repeat (2) @(negedge clk);
        pc = pin_changes; ac = ack_cnt;
        repeat (300) @(negedge clk);
        check(pin_changes == pc && ack_cnt == ac, "R10 no extra work",
              pin_changes - pc + ack_cnt - ac, 0);
        check_log("R10 single frame", '{enc(1, 7, 0)});

        // R8 timeout: device never ready
        log_q.delete();
        hang = 1'b1;
        issue(1, 3, 16'h7777);
        check(err, "R8 timeout error", err, 1);
        check_end_bus("R9 after timeout");
        check_log("R8 no disable", '{enc(3, 3 << (ADDR_W-2), 0), enc(2, 3, 16'h7777)});
        hang = 1'b0;
        @(negedge clk);
        issue(0, 10, 0);
        check(!err && rdata == seed_word(10), "R8 recovery read", rdata, seed_word(10));

        // R3 phase spacing and R5 data-in level over the whole run
        check(phase_viol == 0, "R3 phase spacing", phase_viol, 0);
        check(di_viol == 0, "R5 di low", di_viol, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule